// File: doc/BRIEF.md
# Bus-Holder Pipelined Display RAM Port

This block is the host-facing access port of a display data RAM. All host traffic passes through a single holding register, so every access finishes in one cycle of the system clock and the host never waits. A write puts its byte into the holder and stores the address. On the next cycle the holder is written into the RAM, before any later write can need the holder.

A read puts the holder's current contents on the data bus. In the same cycle it fetches the word at the current address, and that word becomes the holder's new contents. Read data is therefore one access behind. After the address is set, or after a write, the first read is a dummy. The word the host asked for comes back on the following read. The column address advances after every accepted read or write, dummy reads included. It wraps within the current page.

The port has two chip selects, one active low and one active high. While either is inactive, the data bus output enable stays low and the address-set, read and write strobes have no effect. Display scanning and command decoding live elsewhere. The address is loaded through a dedicated address-set strobe with page and column operands.

Top module: `holder_ram_port`

## Requirements
- R1: During reset `dataOe` is 0. After reset the page and column registers are 0 and the holder is 0, so the first accepted read after reset returns 0x00.
- R2: An accepted write (selected, `wrStb`=1, `rdStb`=0) places `dataIn` in the holder. The byte is stored in the RAM word at the current page and column, and the column then advances by one.
- R3: An accepted read (selected, `rdStb`=1, `wrStb`=0) asserts `dataOe` in that same cycle and drives the holder contents on `dataOut`. The RAM word at the current page and column then becomes the holder contents, and the column advances by one.
- R4: After an accepted address set, the first read returns the stale holder contents. The second read returns the word stored at the page and column that were set.
- R5: A read that follows a write, with no other read or write between them, returns the written byte. The read after that returns the word at the column following the written one.
- R6: While `selN`=1 or `sel`=0, `dataOe` is 0 and `dataOut` is 0x00. The `wrStb`, `rdStb` and `addrSet` inputs change neither the RAM, the holder, nor the address.
- R7: A cycle with `rdStb` and `wrStb` both 1 is ignored. `dataOe` stays 0, and the RAM, the holder and the address are unchanged.
- R8: When the column is NUM_COLS-1 (131), a read or write moves it to 0, and the page is unchanged.
- R9: An address set (`addrSet`=1, no read or write strobe) loads `addrPage` and `addrCol` only if `addrPage` < NUM_PAGES (9) and `addrCol` < NUM_COLS (132). Otherwise it is ignored. An address set that is issued together with a read or write strobe is ignored, and the strobe is handled on its own.
- R10: Accepted reads and writes can come on consecutive cycles, in any mix, with no idle cycle and no wait, and each one behaves as in R2 and R3.
- When `dataOe` is 0, `dataOut` is 0x00.
- When `dataOe` is 1, `dataOut` is the value from R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| selN | input | 1 | Chip select, active low |
| sel | input | 1 | Chip select, active high |
| addrSet | input | 1 | Single-cycle address load strobe |
| addrPage | input | PAGE_W (4) | Page operand of an address set |
| addrCol | input | COL_W (8) | Column operand of an address set |
| wrStb | input | 1 | Single-cycle write strobe |
| rdStb | input | 1 | Single-cycle read strobe |
| dataIn | input | DATA_W (8) | Write data from the host |
| dataOut | output | DATA_W (8) | Read data to the host, 0x00 when not driven |
| dataOe | output | 1 | Output enable of the host data bus |

## Verification
The assertions assume that every strobe is synchronous to `clk` and that each strobe pulse is one access. They also assume that the inputs are held at known levels from time zero, with all strobes low during reset. The bench drives every input on the falling clock edge, from a defined value, and keeps the strobes low while reset is applied.

The bench fills the whole RAM before it reads any word whose value matters. Apart from the single read right after reset, a fetch never pulls an unwritten word into the holder. Read data is compared only where the reference model knows the word.

// File: rtl/hrp_pkg.sv
package hrp_pkg;

  // Per-cycle commands from the control to the datapath
  typedef struct packed {
    logic doWrite;  // accepted write this cycle
    logic doRead;   // accepted read this cycle
    logic doAddr;   // accepted address set this cycle
    logic commit;   // holder -> RAM (cycle after a write)
    logic fetch;    // RAM read word is valid (cycle after a read)
  } hrpStb_t;

endpackage

// File: rtl/hrp_ram.sv
module hrp_ram #(
  parameter int DEPTH  = 1188,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] memArr [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) begin
      memArr[wrAddr] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (rdEn) begin
      rdData <= memArr[rdAddr];
    end
  end

endmodule

// File: rtl/hrp_ctrl.sv
module hrp_ctrl
  import hrp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    selN,
  input  logic    sel,
  input  logic    addrSet,
  input  logic    wrStb,
  input  logic    rdStb,
  output hrpStb_t stb,
  output logic    dataOe
);

  logic chipOn;
  logic commitQ;
  logic fetchQ;
  logic wrOnly;
  logic rdOnly;
  logic noAccess;

  assign chipOn   = !selN && sel;
  assign wrOnly   = wrStb && !rdStb;
  assign rdOnly   = rdStb && !wrStb;
  assign noAccess = !wrStb && !rdStb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      commitQ <= 1'b0;
      fetchQ  <= 1'b0;
    end else begin
      commitQ <= chipOn && wrOnly;
      fetchQ  <= chipOn && rdOnly;
    end
  end

  always_comb begin
    stb.doWrite = chipOn && wrOnly;
    stb.doRead  = chipOn && rdOnly;
    stb.doAddr  = chipOn && addrSet && noAccess;
    stb.commit  = commitQ;
    stb.fetch   = fetchQ;
  end

  assign dataOe = stb.doRead;

endmodule

// File: rtl/hrp_datapath.sv
module hrp_datapath
  import hrp_pkg::*;
#(
  parameter int NUM_COLS  = 132,
  parameter int NUM_PAGES = 9,
  parameter int DATA_W    = 8,
  localparam int COL_W  = $clog2(NUM_COLS),
  localparam int PAGE_W = $clog2(NUM_PAGES),
  localparam int DEPTH  = NUM_COLS * NUM_PAGES,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  hrpStb_t           stb,
  input  logic [PAGE_W-1:0] addrPage,
  input  logic [COL_W-1:0]  addrCol,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] holderView
);

  logic [PAGE_W-1:0] pageReg;
  logic [COL_W-1:0]  colReg;
  logic [COL_W-1:0]  colNext;
  logic [ADDR_W-1:0] curIdx;
  logic [ADDR_W-1:0] commitIdx;
  logic [DATA_W-1:0] holderReg;
  logic [DATA_W-1:0] ramQ;
  logic              addrOk;

  // Column step with wrap inside the page
  assign colNext = (colReg == COL_W'(NUM_COLS - 1)) ? '0 : colReg + 1'b1;

  assign addrOk = (int'(addrPage) < NUM_PAGES) && (int'(addrCol) < NUM_COLS);

  assign curIdx = ADDR_W'(int'(pageReg) * NUM_COLS + int'(colReg));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg <= '0;
      colReg  <= '0;
    end else if (stb.doWrite || stb.doRead) begin
      colReg <= colNext;
    end else if (stb.doAddr && addrOk) begin
      pageReg <= addrPage;
      colReg  <= addrCol;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      commitIdx <= '0;
    end else if (stb.doWrite) begin
      commitIdx <= curIdx;
    end
  end

  // Holder: a write overrides a pending fetch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holderReg <= '0;
    end else if (stb.doWrite) begin
      holderReg <= dataIn;
    end else if (stb.fetch) begin
      holderReg <= ramQ;
    end
  end

  // While a fetch is landing, the RAM output is the holder's next value
  assign holderView = stb.fetch ? ramQ : holderReg;

  hrp_ram #(
    .DEPTH (DEPTH),
    .DATA_W(DATA_W)
  ) ram_i (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (stb.commit),
    .wrAddr(commitIdx),
    .wrData(holderReg),
    .rdEn  (stb.doRead),
    .rdAddr(curIdx),
    .rdData(ramQ)
  );

endmodule

// File: rtl/holder_ram_port.sv
module holder_ram_port
  import hrp_pkg::*;
#(
  parameter int NUM_COLS  = 132,
  parameter int NUM_PAGES = 9,
  parameter int DATA_W    = 8,
  localparam int COL_W  = $clog2(NUM_COLS),
  localparam int PAGE_W = $clog2(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selN,
  input  logic              sel,
  input  logic              addrSet,
  input  logic [PAGE_W-1:0] addrPage,
  input  logic [COL_W-1:0]  addrCol,
  input  logic              wrStb,
  input  logic              rdStb,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  hrpStb_t           stb;
  logic [DATA_W-1:0] holderView;

  hrp_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .selN   (selN),
    .sel    (sel),
    .addrSet(addrSet),
    .wrStb  (wrStb),
    .rdStb  (rdStb),
    .stb    (stb),
    .dataOe (dataOe)
  );

  hrp_datapath #(
    .NUM_COLS (NUM_COLS),
    .NUM_PAGES(NUM_PAGES),
    .DATA_W   (DATA_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .addrPage  (addrPage),
    .addrCol   (addrCol),
    .dataIn    (dataIn),
    .holderView(holderView)
  );

  assign dataOut = dataOe ? holderView : '0;

endmodule

// File: rtl/holder_ram_port_chk.sv
module holder_ram_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              selN,
  input logic              sel,
  input logic              wrStb,
  input logic              rdStb,
  input logic [DATA_W-1:0] dataIn,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOe
);

  logic              selOn;
  logic              rdAcc;
  logic              wrAcc;
  logic              seenAcc;
  logic              lastWasWr;
  logic [DATA_W-1:0] lastWrData;

  assign selOn = !selN && sel;
  assign rdAcc = selOn && rdStb && !wrStb;
  assign wrAcc = selOn && wrStb && !rdStb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenAcc    <= 1'b0;
      lastWasWr  <= 1'b0;
      lastWrData <= '0;
    end else begin
      if (rdAcc || wrAcc) seenAcc <= 1'b1;
      if (wrAcc) begin
        lastWasWr  <= 1'b1;
        lastWrData <= dataIn;
      end else if (rdAcc) begin
        lastWasWr <= 1'b0;
      end
    end
  end

  AST_FIRST_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdAcc && !seenAcc) |-> (dataOut == '0)); // R1

  AST_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (rdAcc && lastWasWr) |-> (dataOut == lastWrData)); // R5

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !selOn |-> (!dataOe && dataOut == '0)); // R6

  AST_DUAL_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && wrStb) |-> !dataOe); // R7

endmodule

bind holder_ram_port holder_ram_port_chk #(.DATA_W(DATA_W)) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .selN   (selN),
  .sel    (sel),
  .wrStb  (wrStb),
  .rdStb  (rdStb),
  .dataIn (dataIn),
  .dataOut(dataOut),
  .dataOe (dataOe)
);

// File: tb/holder_ram_port_tb.sv
module holder_ram_port_tb_top;

  localparam int COLS  = 132;
  localparam int PAGES = 9;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       selN = 1'b1;
  logic       sel = 1'b0;
  logic       addrSet = 1'b0;
  logic [3:0] addrPage = '0;
  logic [7:0] addrCol = '0;
  logic       wrStb = 1'b0;
  logic       rdStb = 1'b0;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic       dataOe;

  int    total = 0;
  int    bad = 0;
  string req = "R1";

  // Reference model state
  int memM [COLS*PAGES];
  int holdM;
  int pageM;
  int colM;

  always #5 clk = ~clk;

  holder_ram_port dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .selN    (selN),
    .sel     (sel),
    .addrSet (addrSet),
    .addrPage(addrPage),
    .addrCol (addrCol),
    .wrStb   (wrStb),
    .rdStb   (rdStb),
    .dataIn  (dataIn),
    .dataOut (dataOut),
    .dataOe  (dataOe)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int pat(input int p, input int c);
    return (p * 37 + c * 5 + 3) & 255;
  endfunction

  // One bus cycle: drive on the falling edge, compare, advance the model
  task automatic cyc(input bit sN, input bit s, input bit aS, input int pg, input int cl,
                     input bit w, input bit r, input int d);
    bit en;
    bit expOe;
    @(negedge clk);
    selN = sN; sel = s; addrSet = aS;
    addrPage = 4'(pg); addrCol = 8'(cl);
    wrStb = w; rdStb = r; dataIn = 8'(d);
    #2;
    en    = !sN && s;
    expOe = en && r && !w;
    chk(dataOe == expOe, "dataOe", int'(dataOe), int'(expOe));
    if (expOe && holdM >= 0)
      chk(int'(dataOut) == holdM, "read data", int'(dataOut), holdM);
    if (!expOe)
      chk(dataOut == 8'h00, "idle bus", int'(dataOut), 0);
    if (en && w && !r) begin
      memM[pageM*COLS+colM] = d & 255;
      holdM = d & 255;
      colM = (colM == COLS-1) ? 0 : colM + 1;
    end else if (expOe) begin
      holdM = memM[pageM*COLS+colM];
      colM = (colM == COLS-1) ? 0 : colM + 1;
    end else if (en && aS && !w && !r && pg < PAGES && cl < COLS) begin
      pageM = pg;
      colM = cl;
    end
  endtask

  task automatic wr(input int d);      cyc(0, 1, 0, 0, 0, 1, 0, d); endtask
  task automatic rd();                 cyc(0, 1, 0, 0, 0, 0, 1, 0); endtask
  task automatic setA(input int p, input int c); cyc(0, 1, 1, p, c, 0, 0, 0); endtask
  task automatic idle();               cyc(0, 1, 0, 0, 0, 0, 0, 0); endtask

  initial begin
    #(200000 * 10);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    foreach (memM[i]) memM[i] = -1;
    holdM = 0; pageM = 0; colM = 0;

    // R1: output quiet in reset, first read returns zero
    req = "R1";
    repeat (3) begin
      @(negedge clk);
      chk(dataOe == 1'b0, "dataOe in reset", int'(dataOe), 0);
    end
    @(negedge clk);
    rstN = 1'b1;
    rd();   // returns 0x00 from the reset holder
    chk(holdM == -1, "model fetched unwritten word", holdM, -1);

    // R2 / R8 / R10: fill every page with back-to-back writes, column wraps
    req = "R2";
    for (int p = 0; p < PAGES; p++) begin
      setA(p, 0);
      for (int c = 0; c < COLS; c++) wr(pat(p, c));
    end

    // R8: column wrapped to 0 on the same page
    req = "R8";
    setA(5, COLS-2);
    rd(); rd(); rd(); rd();   // (5,130),(5,131),(5,0) appear one read late

    // R3: consecutive reads stream words one access behind
    req = "R3";
    setA(1, 20);
    for (int k = 0; k < 6; k++) rd();

    // R4: dummy read after address set
    req = "R4";
    setA(3, 50);
    rd();
    rd();
    chk(holdM == pat(3, 51), "holder after second read", holdM, pat(3, 51));
    setA(7, 0); idle(); rd(); rd();

    // R5: read straight after a write returns the written byte
    req = "R5";
    setA(2, 10);
    wr(8'hA5);
    rd();
    rd();
    wr(8'h3C); idle(); idle(); rd(); rd();

    // R6: deselected strobes ignored
    req = "R6";
    setA(4, 7);
    cyc(1, 1, 0, 0, 0, 1, 0, 8'hEE);
    cyc(0, 0, 0, 0, 0, 1, 0, 8'hDD);
    cyc(1, 0, 0, 0, 0, 0, 1, 0);
    cyc(1, 1, 1, 8, 100, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    rd(); rd(); rd();   // still at (4,7): its original pattern appears

    // R7: both strobes together ignored
    req = "R7";
    setA(6, 60);
    cyc(0, 1, 0, 0, 0, 1, 1, 8'h77);
    cyc(0, 1, 0, 0, 0, 1, 1, 8'h78);
    rd(); rd(); rd();

    // R9: out-of-range and colliding address sets ignored
    req = "R9";
    setA(0, 40);
    setA(9, 5);
    setA(2, 132);
    setA(15, 255);
    rd(); rd();
    cyc(0, 1, 1, 8, 3, 0, 1, 0);   // read wins, address not loaded
    rd();
    cyc(0, 1, 1, 1, 1, 1, 0, 8'h5A); // write wins
    rd(); rd();
    setA(PAGES-1, COLS-1);
    rd(); rd(); rd();

    // R10: mixed traffic every cycle, no waits
    req = "R10";
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[2:0])
        3'd0, 3'd1, 3'd2: rd();
        3'd3, 3'd4:       wr(int'(lfsr[15:8]));
        3'd5:             setA(int'(lfsr[11:8]), int'(lfsr[15:8]));
        3'd6:             cyc(lfsr[9], lfsr[10], lfsr[11], 0, 0, lfsr[12], lfsr[13], 8'h99);
        default:          cyc(0, 1, 0, 0, 0, 1, 1, 8'h11);
      endcase
    end

    idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule